// File: doc/BRIEF.md
# Write-Verify Row Memory Controller

This controller sits between a fast CPU clock domain and a slow, retention-optimised SRAM array of 52 rows by 40 bits. The array write does not finish in a fixed number of cycles. After a CPU write is accepted, the controller keeps the write strobe, row and data applied to the array. In every cycle it reads that row back and compares it with the requested word. Once the row reads back correctly, the controller waits a further programmable replica delay, because the single-ended read path can report a match before both sides of the cell have settled. Only then does it acknowledge the CPU. Reads are taken from the array in one cycle.

The CPU holds a request with its address and data stable until it sees a one-cycle acknowledge. The state machine has four states. IDLE accepts requests. VERIFY drives the write and compares the read-back. REPLICA counts the settle delay. ACK pulses the acknowledge. The transitions are:
- IDLE to ACK on a read request, capturing the row contents.
- IDLE to VERIFY on a write request.
- VERIFY to REPLICA when the read-back equals the write data.
- VERIFY to ACK on timeout, which also sets the error flag.
- REPLICA to ACK when the delay count reaches zero.
- ACK to IDLE always.

A write that never verifies is still acknowledged after a bounded time, and a sticky error flag records the event.

Top module: `wv_mem_ctrl`

## Requirements
- R1: After reset, `cpu_ack`, `arr_wr_req` and `cpu_err` are all 0.
- R2: A read request accepted in IDLE is acknowledged in the next cycle. In that acknowledge cycle, `cpu_rdata` holds the word stored at row `cpu_addr`.
- R3: From the cycle after a write is accepted until the acknowledge cycle, `arr_wr_req` is 1 and `arr_row` and `arr_wdata` stay constant at the accepted row and data. In the acknowledge cycle, `arr_wr_req` is 0.
- R4: `cpu_ack` for a write rises exactly N+1 cycles after the first cycle in which `arr_rdata` equals the write data. N is the replica delay latched when the write is accepted.
- R5: `cpu_replica` values 1 to 15 give N equal to that value. A value of 0 selects the default N = 4.
- R6: If the read-back has not matched after 64 cycles with `arr_wr_req` high, the write is acknowledged in the 65th cycle and `cpu_err` becomes 1.
- R7: `cpu_err` stays 1 until reset once it is set. Writes that verify never set it.
- R8: `cpu_ack` is a single-cycle pulse and is never raised without a request.
- R9: Requests are accepted only in IDLE, so a read issued after a write acknowledge returns the newly written word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_req | input | 1 | Request valid, held until acknowledge |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 6 | Row index, 0 to 51 |
| cpu_wdata | input | 40 | Write word |
| cpu_replica | input | 4 | Replica delay in cycles, 0 selects the default |
| cpu_ack | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 40 | Read word, valid while `cpu_ack` is high after a read |
| cpu_err | output | 1 | Sticky write-timeout flag |
| arr_wr_req | output | 1 | Array write strobe, held during verify and replica |
| arr_row | output | 6 | Array row for write and read-back |
| arr_wdata | output | 40 | Array write word |
| arr_rdata | input | 40 | Array read-back of `arr_row` |

## Verification
Several properties are checked on every cycle:
- the acknowledge is a single-cycle pulse;
- the write row and data stay constant while the strobe is high;
- the strobe is low whenever the acknowledge is high;
- the error flag never clears;
- the latched replica delay is never zero;
- a timeout or an expired replica count is followed by an acknowledge.

Only the bench scenarios can show the exact distance between the first matching read-back and the acknowledge, because it depends on the array model's random write latency and on the configured delay. The same holds for the read data, for the 64-cycle timeout against an array that never takes the write, and for read-after-write ordering.

// File: rtl/wv_pkg.sv
package wv_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_VERIFY  = 2'd1,
        ST_REPLICA = 2'd2,
        ST_ACK     = 2'd3
    } wv_state_e;

endpackage

// File: rtl/wv_row_compare.sv
module wv_row_compare #(
    parameter int WIDTH = 40,
    parameter int SLICE = 8
) (
    input  logic [WIDTH-1:0] lhs,
    input  logic [WIDTH-1:0] rhs,
    output logic             equal
);
    localparam int NSL  = (WIDTH + SLICE - 1) / SLICE;
    localparam int PADW = NSL * SLICE;

    logic [PADW-1:0] lhs_p;
    logic [PADW-1:0] rhs_p;
    logic [NSL-1:0]  slice_eq;

    assign lhs_p = PADW'(lhs);
    assign rhs_p = PADW'(rhs);

    // per-slice equality, reduced in a shallow AND tree
    for (genvar i = 0; i < NSL; i++) begin : g_slice
        assign slice_eq[i] = (lhs_p[i*SLICE +: SLICE] == rhs_p[i*SLICE +: SLICE]);
    end

    assign equal = &slice_eq;

endmodule

// File: rtl/wv_replica_timer.sv
module wv_replica_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         run,
    output logic         done
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (run && (cnt != '0)) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign done = (cnt == '0);

endmodule

// File: rtl/wv_timeout_ctr.sv
module wv_timeout_ctr #(
    parameter int LIMIT = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic hit
);
    localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!en) begin
            cnt <= '0;
        end else if (!hit) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign hit = en && (cnt == CW'(LIMIT - 1));

endmodule

// File: rtl/wv_mem_ctrl.sv
module wv_mem_ctrl
    import wv_pkg::*;
#(
    parameter int ROWS          = 52,
    parameter int WIDTH         = 40,
    parameter int REPL_W        = 4,
    parameter int REPL_DEFAULT  = 4,
    parameter int TIMEOUT       = 64,
    parameter int CMP_SLICE     = 8,
    localparam int AW           = $clog2(ROWS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [AW-1:0]     cpu_addr,
    input  logic [WIDTH-1:0]  cpu_wdata,
    input  logic [REPL_W-1:0] cpu_replica,
    output logic              cpu_ack,
    output logic [WIDTH-1:0]  cpu_rdata,
    output logic              cpu_err,
    output logic              arr_wr_req,
    output logic [AW-1:0]     arr_row,
    output logic [WIDTH-1:0]  arr_wdata,
    input  logic [WIDTH-1:0]  arr_rdata
);

    wv_state_e         state, nxt;
    logic [AW-1:0]     row_q;
    logic [WIDTH-1:0]  data_q;
    logic [WIDTH-1:0]  rdata_q;
    logic [REPL_W-1:0] repl_q;
    logic              err_q;
    logic              match;
    logic              tmo_hit;
    logic              repl_done;
    logic              repl_load;
    logic              acc_rd;
    logic              acc_wr;

    assign acc_rd    = (state == ST_IDLE) && cpu_req && !cpu_we;
    assign acc_wr    = (state == ST_IDLE) && cpu_req &&  cpu_we;
    assign repl_load = (state == ST_VERIFY) && match;

    wv_row_compare #(.WIDTH(WIDTH), .SLICE(CMP_SLICE)) u_cmp (
        .lhs   (arr_rdata),
        .rhs   (data_q),
        .equal (match)
    );

    wv_timeout_ctr #(.LIMIT(TIMEOUT)) u_tmo (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (state == ST_VERIFY),
        .hit   (tmo_hit)
    );

    wv_replica_timer #(.W(REPL_W)) u_repl (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (repl_load),
        .load_val (repl_q - 1'b1),
        .run      (state == ST_REPLICA),
        .done     (repl_done)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (acc_rd)      nxt = ST_ACK;
                else if (acc_wr) nxt = ST_VERIFY;
            end
            ST_VERIFY: begin
                if (match)        nxt = ST_REPLICA;
                else if (tmo_hit) nxt = ST_ACK;
            end
            ST_REPLICA: begin
                if (repl_done) nxt = ST_ACK;
            end
            ST_ACK: nxt = ST_IDLE;
        endcase
    end

    // captured request fields, read data and sticky error
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            row_q   <= '0;
            data_q  <= '0;
            rdata_q <= '0;
            repl_q  <= REPL_W'(REPL_DEFAULT);
            err_q   <= 1'b0;
        end else begin
            if (acc_wr) begin
                row_q  <= cpu_addr;
                data_q <= cpu_wdata;
                repl_q <= (cpu_replica == '0) ? REPL_W'(REPL_DEFAULT) : cpu_replica;
            end
            if (acc_rd) begin
                rdata_q <= arr_rdata;
            end
            if ((state == ST_VERIFY) && !match && tmo_hit) begin
                err_q <= 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        cpu_ack    = (state == ST_ACK);
        cpu_rdata  = rdata_q;
        cpu_err    = err_q;
        arr_wr_req = (state == ST_VERIFY) || (state == ST_REPLICA);
        arr_row    = (state == ST_IDLE) ? cpu_addr : row_q;
        arr_wdata  = data_q;
    end

    // R8
    ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ack |=> !cpu_ack);

    // R3
    wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_wr_req && $past(arr_wr_req)) |-> ($stable(arr_row) && $stable(arr_wdata)));

    // R3
    ack_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ack |-> !arr_wr_req);

    // R7
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_err |=> cpu_err);

    // R5
    repl_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arr_wr_req |-> (repl_q != '0));

    // R6
    tmo_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_VERIFY && tmo_hit && !match) |=> (cpu_ack && cpu_err));

    // R4
    repl_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_REPLICA && repl_done) |=> cpu_ack);

endmodule

// File: tb/wv_mem_ctrl_tb.sv
module wv_mem_ctrl_tb;

    localparam int ROWS = 52;
    localparam int W    = 40;
    localparam int AW   = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cpu_req = 1'b0;
    logic          cpu_we = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic [W-1:0]  cpu_wdata = '0;
    logic [3:0]    cpu_replica = '0;
    logic          cpu_ack;
    logic [W-1:0]  cpu_rdata;
    logic          cpu_err;
    logic          arr_wr_req;
    logic [AW-1:0] arr_row;
    logic [W-1:0]  arr_wdata;
    logic [W-1:0]  arr_rdata;

    always #2 clk = ~clk;

    wv_mem_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_replica(cpu_replica),
        .cpu_ack(cpu_ack), .cpu_rdata(cpu_rdata), .cpu_err(cpu_err),
        .arr_wr_req(arr_wr_req), .arr_row(arr_row), .arr_wdata(arr_wdata),
        .arr_rdata(arr_rdata)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit ended  = 0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [W-1:0] init_word(int i);
        return {8'hA5, 32'(i) * 32'h01F3_0B17};
    endfunction

    function automatic int eff_delay(logic [3:0] cfg);
        return (cfg == 4'd0) ? 4 : int'(cfg);
    endfunction

    // behavioural slow array: write lands a random number of cycles after strobe
    logic [W-1:0] mem [0:ROWS-1];
    logic [W-1:0] exp_mem [0:ROWS-1];
    int  mlat   = 0;
    int  mcnt   = 0;
    bit  mdone  = 0;
    bit  mstuck = 0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < ROWS; i++) mem[i] <= init_word(i);
            mcnt  <= 0;
            mdone <= 0;
        end else if (arr_wr_req) begin
            if (!mdone && !mstuck) begin
                if (mcnt >= mlat) begin
                    mem[arr_row] <= arr_wdata;
                    mdone <= 1;
                end else begin
                    mcnt <= mcnt + 1;
                end
            end
        end else begin
            mcnt  <= 0;
            mdone <= 0;
        end
    end

    assign arr_rdata = (int'(arr_row) < ROWS) ? mem[arr_row] : '0;

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic do_read(int row);
        int t0;
        @(negedge clk);
        cpu_req = 1; cpu_we = 0; cpu_addr = AW'(row);
        t0 = cyc;
        @(negedge clk);
        check(cpu_ack == 1'b1 && cyc - t0 == 1, "R2", "read ack latency", longint'(cpu_ack), 1);
        check(cpu_rdata == exp_mem[row], "R2", "read data", longint'(cpu_rdata), longint'(exp_mem[row]));
        cpu_req = 0;
        @(negedge clk);
        check(cpu_ack == 1'b0, "R8", "ack pulse after read", longint'(cpu_ack), 0);
    endtask

    task automatic do_write(int row, logic [W-1:0] data, logic [3:0] cfg, int lat, bit stuck);
        int  first_wr = -1;
        int  first_m  = -1;
        int  ack_at   = -1;
        bit  hold_ok  = 1;
        bit  err_pre  = 0;
        int  n;
        mlat   = lat;
        mstuck = stuck;
        @(negedge clk);
        cpu_req = 1; cpu_we = 1; cpu_addr = AW'(row); cpu_wdata = data; cpu_replica = cfg;
        for (int k = 0; k < 300; k++) begin
            @(negedge clk);
            if (cpu_ack) begin
                ack_at = cyc;
                break;
            end
            if (arr_wr_req) begin
                if (first_wr < 0) first_wr = cyc;
                if (arr_row != AW'(row) || arr_wdata != data) hold_ok = 0;
                if (first_m < 0 && arr_rdata == data) first_m = cyc;
                if (cpu_err) err_pre = 1;
            end else begin
                hold_ok = 0;
            end
        end
        cpu_req = 0;
        check(ack_at >= 0, "R3", "write acknowledged", longint'(ack_at), 0);
        check(hold_ok, "R3", "strobe/row/data held until ack", longint'(hold_ok), 1);
        check(arr_wr_req == 1'b0, "R3", "strobe low in ack cycle", longint'(arr_wr_req), 0);
        if (stuck) begin
            check(ack_at - first_wr == 64, "R6", "timeout ack distance", longint'(ack_at - first_wr), 64);
            check(cpu_err == 1'b1, "R6", "error flag on timeout", longint'(cpu_err), 1);
        end else begin
            n = eff_delay(cfg);
            check(first_m >= 0 && ack_at - first_m == n + 1,
                  (cfg == 0) ? "R5" : "R4", "match-to-ack distance",
                  longint'(ack_at - first_m), longint'(n + 1));
            exp_mem[row] = data;
        end
        @(negedge clk);
        check(cpu_ack == 1'b0, "R8", "ack pulse after write", longint'(cpu_ack), 0);
        if (!stuck && !err_pre) check(cpu_err == 1'b0 || ended, "R7", "no error on verified write", longint'(cpu_err), 0);
    endtask

    task automatic apply_reset();
        rst_n = 0;
        repeat (3) @(negedge clk);
        for (int i = 0; i < ROWS; i++) exp_mem[i] = init_word(i);
        rst_n = 1;
        @(negedge clk);
        check(cpu_ack == 0 && arr_wr_req == 0 && cpu_err == 0, "R1", "reset outputs",
              longint'({cpu_ack, arr_wr_req, cpu_err}), 0);
    endtask

    initial begin
        int r;
        logic [W-1:0] d;
        r = $urandom(32'd20240611);
        apply_reset();

        // R8: idle with no request
        repeat (4) begin
            @(negedge clk);
            check(cpu_ack == 0 && arr_wr_req == 0, "R8", "idle without request",
                  longint'({cpu_ack, arr_wr_req}), 0);
        end

        do_read(0);
        do_read(51);
        do_write(3, 40'h12_3456_789A, 4'd1, 0, 0);
        do_write(4, 40'hFF_0000_FFFF, 4'd15, 5, 0);
        do_write(5, 40'h0F_F0F0_0F0F, 4'd0, 2, 0);     // R5 default
        do_write(6, exp_mem[6], 4'd3, 7, 0);           // R4 immediate match
        do_read(3);                                    // R9 read after write
        do_read(5);

        for (int k = 0; k < 40; k++) begin
            r = int'($urandom_range(ROWS - 1, 0));
            if ($urandom_range(1, 0) == 1) begin
                d = {8'($urandom), $urandom};
                do_write(r, d, 4'($urandom_range(15, 0)), int'($urandom_range(12, 0)), 0);
                do_read(r);                            // R9
            end else begin
                do_read(r);
            end
        end

        check(cpu_err == 1'b0, "R7", "error clear after verified writes", longint'(cpu_err), 0);
        do_write(10, ~exp_mem[10], 4'd2, 0, 1);        // R6 timeout
        do_read(10);
        do_write(11, 40'hAB_CDEF_0123, 4'd6, 3, 0);
        check(cpu_err == 1'b1, "R7", "error stays set", longint'(cpu_err), 1);
        mstuck = 0;
        apply_reset();                                 // R1, R7 cleared only by reset

        ended = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!ended) begin
            ended = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

endmodule